// File: doc/BRIEF.md
# Crossbar Configuration Command Decoder

This block takes a stream of configuration bytes and keeps the routing map of a square link crossbar with 32 inputs and 32 outputs. Each command is one opcode byte followed by zero, one or two operand bytes. Commands can route one input to one output, pair two links in both directions, drop one output, unpair two links, read back the input feeding an output, commit the pending map, or wipe every route. Bytes arrive on a valid/ready channel. Query answers leave on a second valid/ready channel.

Routing edits go to a staged table. The fabric is driven by a separate active table, which changes only on a commit or a wipe. A whole new topology therefore reaches the select and enable outputs in a single clock edge. Queries read the staged table, so software can check pending edits before it commits them.

The fabric itself is outside this block. It consumes one select field and one enable bit per output. Byte-level link framing is also outside the block.

Top module: `xbar_cfg_decoder`

## Requirements
- R1: After reset every bit of linkEn is 0, respValid is 0 and inReady is 1.
- R2: Opcode byte 0x00, then an input number, then an output number, routes that input to that output in the staged table. The linkSel and linkEn outputs do not change until a commit.
- R3: Routing to an output that already has an input replaces the old input with the new one.
- R4: Opcode byte 0x01, then link A, then link B, stages two routes: input A to output B, and input B to output A.
- R5: Opcode byte 0x02, then an output number, produces one reply byte built from the staged table. If the output is routed, the reply is the input number with bit 7 at 0. If the output is unrouted, the reply is 0x80.
- R6: A reply stays on respValid with an unchanged respData until respReady is high. While the reply waits, inReady is 0.
- R7: Opcode byte 0x04 clears the staged table and the active table on the same edge. linkEn is all 0 in the next cycle, and later queries return 0x80.
- R8: Opcode byte 0x05, then an output number, unroutes that output in the staged table.
- R9: Opcode byte 0x06, then link A, then link B, makes two conditional changes. It unroutes output B if output B is fed by input A. It unroutes output A if output A is fed by input B. No other output changes.
- R10: In every operand byte only bits 4:0 select a link. Bits 7:5 are ignored.
- R11: Opcode bytes 0x07 to 0xFF are discarded, and the byte that follows is taken as a new opcode.
- R12: Opcode byte 0x03 copies the whole staged table into the active table, which drives linkSel and linkEn. The active table changes only on 0x03 or 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A command byte is offered |
| inData | input | 8 | Command or operand byte |
| inReady | output | 1 | The block accepts the offered byte on this edge |
| respValid | output | 1 | A query reply is waiting |
| respData | output | 8 | Query reply byte |
| respReady | input | 1 | The receiver takes the reply on this edge |
| linkSel | output | NUM_LINKS*LINK_W | Input number for each output; output o uses bits [o*LINK_W +: LINK_W] |
| linkEn | output | NUM_LINKS | Bit o enables fabric output o |

## Verification
The bench builds the block with the default NUM_LINKS of 32, so each link field is exactly five bits wide. Link numbers 0 and 31 are therefore both legal operands and both appear in the tests. Operand bytes with bits 7:5 set then test the masking rule, and opcode bytes 0x07 and 0xFF test the discard path. The bench holds respReady low across a query to exercise the stalled reply.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

  typedef enum logic [2:0] {
    OP_ROUTE  = 3'd0,
    OP_PAIR   = 3'd1,
    OP_QUERY  = 3'd2,
    OP_COMMIT = 3'd3,
    OP_WIPE   = 3'd4,
    OP_DROP   = 3'd5,
    OP_UNPAIR = 3'd6
  } opcode_e;

  // One-cycle strobes from the parser to the routing tables
  typedef struct packed {
    logic route;
    logic pair;
    logic query;
    logic commit;
    logic wipe;
    logic drop;
    logic unpair;
  } strobe_t;

  localparam logic [7:0] LAST_OPCODE = 8'd6;
  localparam logic [7:0] UNROUTED_REPLY = 8'h80;

endpackage

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
  import xbar_cfg_pkg::*;
#(
  parameter int LINK_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              inReady,
  input  logic              respReady,
  output logic              respValid,
  output strobe_t           strb,
  output logic [LINK_W-1:0] opFirst,
  output logic [LINK_W-1:0] opSecond
);

  typedef enum logic [1:0] {S_IDLE, S_ARG1, S_ARG2, S_RESP} state_e;

  state_e            state, nextState;
  opcode_e           cmdQ;
  logic [LINK_W-1:0] firstQ;
  logic              accept;

  assign inReady   = (state != S_RESP);
  assign respValid = (state == S_RESP);
  assign accept    = inValid && inReady;
  assign opFirst   = firstQ;
  assign opSecond  = inData[LINK_W-1:0];

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (accept && inData <= LAST_OPCODE) begin
          case (opcode_e'(inData[2:0]))
            OP_COMMIT: strb.commit = 1'b1;
            OP_WIPE:   strb.wipe   = 1'b1;
            default:   nextState   = S_ARG1;
          endcase
        end
      end
      S_ARG1: begin
        if (accept) begin
          case (cmdQ)
            OP_QUERY: begin
              strb.query = 1'b1;
              nextState  = S_RESP;
            end
            OP_DROP: begin
              strb.drop = 1'b1;
              nextState = S_IDLE;
            end
            default: nextState = S_ARG2;
          endcase
        end
      end
      S_ARG2: begin
        if (accept) begin
          case (cmdQ)
            OP_ROUTE:  strb.route  = 1'b1;
            OP_PAIR:   strb.pair   = 1'b1;
            OP_UNPAIR: strb.unpair = 1'b1;
            default:   ;
          endcase
          nextState = S_IDLE;
        end
      end
      S_RESP: begin
        if (respReady) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cmdQ   <= OP_ROUTE;
      firstQ <= '0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && accept) cmdQ <= opcode_e'(inData[2:0]);
      if (state == S_ARG1 && accept) firstQ <= inData[LINK_W-1:0];
    end
  end

  // R11
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && accept && inData > LAST_OPCODE) |=> state == S_IDLE);

  // R6
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> (respValid && !inReady));

  // R12
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/xbar_cfg_table.sv
module xbar_cfg_table
  import xbar_cfg_pkg::*;
#(
  parameter int NUM_LINKS = 32,
  parameter int LINK_W    = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           strb,
  input  logic [LINK_W-1:0]                 opFirst,
  input  logic [LINK_W-1:0]                 opSecond,
  output logic [7:0]                        respData,
  output logic [NUM_LINKS-1:0][LINK_W-1:0]  actSel,
  output logic [NUM_LINKS-1:0]              actEn
);

  localparam int PAD_W = 8 - LINK_W;

  logic [NUM_LINKS-1:0][LINK_W-1:0] stgSel;
  logic [NUM_LINKS-1:0]             stgEn;

  for (genvar o = 0; o < NUM_LINKS; o++) begin : g_out
    logic              hitA, hitB, setEn, clrEn;
    logic [LINK_W-1:0] setVal;
    logic              stgEnQ, actEnQ;
    logic [LINK_W-1:0] stgSelQ, actSelQ;

    always_comb begin
      hitA   = (opFirst  == LINK_W'(o));
      hitB   = (opSecond == LINK_W'(o));
      setEn  = 1'b0;
      setVal = opFirst;
      clrEn  = 1'b0;
      if (strb.route && hitB) setEn = 1'b1;
      if (strb.pair) begin
        if (hitB) begin
          setEn = 1'b1;
        end else if (hitA) begin
          setEn  = 1'b1;
          setVal = opSecond;
        end
      end
      if (strb.drop && hitB) clrEn = 1'b1;
      if (strb.unpair && stgEnQ) begin
        if (hitB && stgSelQ == opFirst)  clrEn = 1'b1;
        if (hitA && stgSelQ == opSecond) clrEn = 1'b1;
      end
      if (strb.wipe) clrEn = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stgEnQ  <= 1'b0;
        stgSelQ <= '0;
      end else if (clrEn) begin
        stgEnQ  <= 1'b0;
        stgSelQ <= '0;
      end else if (setEn) begin
        stgEnQ  <= 1'b1;
        stgSelQ <= setVal;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || strb.wipe) begin
        actEnQ  <= 1'b0;
        actSelQ <= '0;
      end else if (strb.commit) begin
        actEnQ  <= stgEnQ;
        actSelQ <= stgSelQ;
      end
    end

    assign stgEn[o]  = stgEnQ;
    assign stgSel[o] = stgSelQ;
    assign actEn[o]  = actEnQ;
    assign actSel[o] = actSelQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respData <= '0;
    end else if (strb.query) begin
      respData <= stgEn[opSecond] ? {{PAD_W{1'b0}}, stgSel[opSecond]}
                                  : UNROUTED_REPLY;
    end
  end

  // R7
  wipe_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> (actEn == '0 && stgEn == '0));

  // R12
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (actEn == $past(stgEn) && actSel == $past(stgSel)));

  // R12
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !strb.wipe) |=> ($stable(actEn) && $stable(actSel)));

  // R2
  route_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.route |=> (stgEn[$past(opSecond)] &&
                    stgSel[$past(opSecond)] == $past(opFirst)));

endmodule

// File: rtl/xbar_cfg_decoder.sv
module xbar_cfg_decoder
  import xbar_cfg_pkg::*;
#(
  parameter int NUM_LINKS = 32,
  localparam int LINK_W   = $clog2(NUM_LINKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [7:0]                  inData,
  output logic                        inReady,
  output logic                        respValid,
  output logic [7:0]                  respData,
  input  logic                        respReady,
  output logic [NUM_LINKS*LINK_W-1:0] linkSel,
  output logic [NUM_LINKS-1:0]        linkEn
);

  strobe_t                          strb;
  logic [LINK_W-1:0]                opFirst, opSecond;
  logic [NUM_LINKS-1:0][LINK_W-1:0] actSel;

  xbar_cfg_ctrl #(.LINK_W(LINK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .respReady(respReady), .respValid(respValid),
    .strb(strb), .opFirst(opFirst), .opSecond(opSecond)
  );

  xbar_cfg_table #(.NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W)) u_table (
    .clk(clk), .rstN(rstN), .strb(strb), .opFirst(opFirst),
    .opSecond(opSecond), .respData(respData), .actSel(actSel), .actEn(linkEn)
  );

  assign linkSel = actSel;

  // R6
  reply_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> $stable(respData));

endmodule

// File: tb/sim_xbar_cfg_decoder.sv
`timescale 1ns/1ps
module sim_xbar_cfg_decoder;

  localparam int N = 32;
  localparam int W = 5;

  logic         clk = 0;
  logic         rstN = 0;
  logic         inValid = 0;
  logic [7:0]   inData = 0;
  logic         inReady;
  logic         respValid;
  logic [7:0]   respData;
  logic         respReady = 1;
  logic [N*W-1:0] linkSel;
  logic [N-1:0] linkEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit       mEnS [N];
  int       mSelS[N];
  bit       mEnA [N];
  int       mSelA[N];
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  xbar_cfg_decoder #(.NUM_LINKS(N)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .respValid(respValid), .respData(respData),
    .respReady(respReady), .linkSel(linkSel), .linkEn(linkEn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: every reply handshake pops one expected byte
  always @(negedge clk) begin
    if (rstN && respValid && respReady) begin
      if (expQ.size() == 0) begin
        check(0, "R5 unexpected reply", respData, 0);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(respData == e, t, respData, e);
      end
    end
  end

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1;
    inData  = b;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 0;
  endtask

  task automatic doRoute(input logic [7:0] a, input logic [7:0] b);
    sendByte(8'h00); sendByte(a); sendByte(b);
    mEnS[b[4:0]] = 1; mSelS[b[4:0]] = a[4:0];
  endtask

  task automatic doPair(input int a, input int b);
    sendByte(8'h01); sendByte(8'(a)); sendByte(8'(b));
    mEnS[b] = 1; mSelS[b] = a;
    mEnS[a] = 1; mSelS[a] = b;
  endtask

  task automatic doQuery(input int o, input string tag);
    expQ.push_back(mEnS[o] ? 8'(mSelS[o]) : 8'h80);
    tagQ.push_back(tag);
    sendByte(8'h02); sendByte(8'(o));
  endtask

  task automatic doDrop(input int o);
    sendByte(8'h05); sendByte(8'(o));
    mEnS[o] = 0;
  endtask

  task automatic doUnpair(input int a, input int b);
    bit clrB, clrA;
    sendByte(8'h06); sendByte(8'(a)); sendByte(8'(b));
    clrB = mEnS[b] && mSelS[b] == a;
    clrA = mEnS[a] && mSelS[a] == b;
    if (clrB) mEnS[b] = 0;
    if (clrA) mEnS[a] = 0;
  endtask

  task automatic doCommit();
    sendByte(8'h03);
    for (int o = 0; o < N; o++) begin
      mEnA[o] = mEnS[o]; mSelA[o] = mSelS[o];
    end
  endtask

  task automatic doWipe();
    sendByte(8'h04);
    for (int o = 0; o < N; o++) begin
      mEnS[o] = 0; mEnA[o] = 0;
    end
  endtask

  task automatic checkActive(input string tag);
    int bad = -1;
    @(negedge clk);
    for (int o = 0; o < N; o++) begin
      if (bad < 0 && (linkEn[o] != mEnA[o] ||
          (mEnA[o] && int'(linkSel[o*W +: W]) != mSelA[o]))) bad = o;
    end
    if (bad < 0) check(1, tag, 0, 0);
    else check(0, {tag, " output mismatch"},
               {linkEn[bad], 3'b0, linkSel[bad*W +: W]},
               {mEnA[bad], 3'b0, 5'(mSelA[bad])});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int o = 0; o < N; o++) begin
      mEnS[o] = 0; mSelS[o] = 0; mEnA[o] = 0; mSelA[o] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1
    check(linkEn == '0, "R1 enables after reset", linkEn, 0);
    check(respValid == 0, "R1 respValid after reset", respValid, 0);
    check(inReady == 1, "R1 inReady after reset", inReady, 1);

    // R2: staged only until commit
    doRoute(8'd3, 8'd7);
    checkActive("R2 no change before commit");
    doCommit();
    checkActive("R2 route after commit");

    // R3: replace
    doRoute(8'd5, 8'd7);
    doQuery(7, "R3 replaced input read back");
    doCommit();
    checkActive("R3 replaced route");

    // R5: unrouted query
    doQuery(9, "R5 unrouted reply");

    // R4: pairing, including link 31 and 0
    doPair(10, 20);
    doPair(31, 0);
    doCommit();
    checkActive("R4 pair routes");
    doQuery(20, "R4 out20 fed by 10");
    doQuery(10, "R4 out10 fed by 20");
    doQuery(0, "R4 out0 fed by 31");

    // R8: drop
    doDrop(7);
    doQuery(7, "R8 dropped output");
    doCommit();
    checkActive("R8 drop committed");

    // R9: unpair both, and a non-matching unpair leaves routes
    doUnpair(10, 20);
    doRoute(8'd2, 8'd15);
    doUnpair(2, 16);
    doQuery(15, "R9 unrelated route kept");
    doQuery(20, "R9 unpaired out20");
    doCommit();
    checkActive("R9 unpair committed");

    // R10: upper operand bits ignored
    doRoute(8'hE1, 8'hA6);
    doQuery(6, "R10 masked operands");
    doCommit();
    checkActive("R10 masked route");

    // R11: unknown opcodes discarded
    sendByte(8'h07);
    sendByte(8'hFF);
    doQuery(6, "R11 parse after unknown");
    sendByte(8'h07);
    doCommit();
    checkActive("R11 commit after unknown");

    // R6: stalled reply
    respReady = 0;
    expQ.push_back(8'h01);
    tagQ.push_back("R6 stalled reply delivered");
    sendByte(8'h02); sendByte(8'h06);
    @(negedge clk);
    check(respValid == 1, "R6 reply waiting", respValid, 1);
    check(respData == 8'h01, "R6 reply data", respData, 8'h01);
    repeat (4) @(negedge clk);
    check(respValid == 1, "R6 reply held", respValid, 1);
    check(inReady == 0, "R6 input stalled", inReady, 0);
    check(respData == 8'h01, "R6 reply data held", respData, 8'h01);
    @(posedge clk);
    #1 respReady = 1;
    @(negedge clk);
    @(negedge clk);
    check(respValid == 0, "R6 reply consumed", respValid, 0);

    // R7: wipe clears both tables
    doWipe();
    @(negedge clk);
    check(linkEn == '0, "R7 enables cleared", linkEn, 0);
    doQuery(6, "R7 staged cleared");
    doQuery(0, "R7 staged cleared out0");

    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R5 all replies seen", expQ.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule